// File: doc/BRIEF.md
# Queued SPI Conversion Sequencer

This block is a free-running SPI master that paces a 16-bit serial-output sampling ADC without any processor help. A fixed two-entry command queue alternates between a short 8-bit frame, in which both the convert strobe and the device select are pulled low so that a conversion starts, and a 16-bit frame, in which only the device select is low and the finished result is clocked in. After every frame a programmable quiet time holds both selects high. The queue then wraps, so the sample instant is derived from the system clock alone and carries no software jitter.

Each queue entry is a command byte. Bit 6 picks the frame length (0 gives 8 bits, 1 gives 16 bits). Bit 5 turns the post-frame quiet time on. Bit 4 would request a select-to-clock lead and is clear in both entries. Bits 3:0 carry select levels, where bit 0 drives the convert strobe and bit 1 drives the device select. The start entry is 0x20 and the read entry is 0x61. The serial clock runs in mode 0 with a half period of `baud_div` system clocks. The quiet time is 32 times `post_dt` system clocks.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `conv_n` and `cs_n` are high, `sclk` is low and `result_valid` is low.
- R2: While `baud_div` is 0 the sequencer stays idle even with `enable` high, and no frame is started.
- R3: The start frame (command 0x20, bits 3:0 = 0000) holds `conv_n` and `cs_n` low for 8 rising `sclk` edges. The read frame (command 0x61, bits 3:0 = 0001) holds only `cs_n` low, with `conv_n` high, for 16 rising edges. `conv_n` is never low while `cs_n` is high.
- R4: Frames alternate start, read, start, read. The first frame after leaving idle is always a start frame.
- R5: `sclk` idles low, and each half period lasts `baud_div` system clocks. A frame of N bits therefore keeps `cs_n` low for exactly 2·N·`baud_div` cycles, and `sclk` is low whenever `cs_n` is high.
- R6: Between two frames both selects stay high for exactly 32·`post_dt` cycles, and a `post_dt` of 0 gives 32·256 = 8192 cycles.
- R7: `sdi` is sampled on rising `sclk` edges, MSB first. `result` equals the 16 bits shifted in during the read frame.
- R8: `result_valid` is a single-cycle pulse raised once per queue pass, during the read frame and never for the start frame. Start-frame data does not reach `result`.
- R9: Dropping `enable` stops the sequencer only after the read frame and its quiet time complete. No further frame follows, and both selects end high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; sampled at the end of each queue pass |
| baud_div | input | DIV_W | Serial clock half period in system clocks; 0 disables |
| post_dt | input | DT_W | Quiet time after each frame, in units of 32 clocks; 0 means 256 |
| sdi | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock, mode 0 |
| conv_n | output | 1 | Active-low convert strobe (select level bit 0) |
| cs_n | output | 1 | Active-low device select (select level bit 1) |
| result | output | RES_W | Last converted sample |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench builds the block with its defaults: an 8-bit divider, an 8-bit quiet-time field scaled by 32, and 8/16-bit frames. With these values the wrapped quiet-time case (`post_dt` of 0, 8192 cycles) and the fastest divider of 1 both fit in one run, next to a slow divider of 40 and seeded random settings. A behavioural ADC model shifts a fresh random word out on falling clock edges. Monitors measure frame lengths, quiet gaps, edge counts and entry order against the stated formulas, and a stop request issued mid-pass checks that the pass still completes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    // One queue entry, laid out as the command byte
    typedef struct packed {
        logic       rsvd;
        logic       wide;      // 1: long frame, 0: short frame
        logic       post_dly;  // quiet time after frame
        logic       lead_dly;  // select-to-clock lead (unused here)
        logic [3:0] sel_lvl;   // [0] convert strobe, [1] device select
    } cmd_t;

    localparam cmd_t CMD_START = cmd_t'(8'h20);
    localparam cmd_t CMD_READ  = cmd_t'(8'h61);

    // Number of system clocks in a quiet time, zero field wraps to max
    function automatic int unsigned post_cycles(int unsigned dt,
                                                int unsigned dt_w,
                                                int unsigned scale_log2);
        int unsigned eff;
        eff = (dt == 0) ? (32'd1 << dt_w) : dt;
        return eff << scale_log2;
    endfunction

endpackage

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] half_q;
    logic             sclk_q;
    logic             tick;

    assign tick = run && (half_q == divisor - 1'b1);
    assign rise = tick && !sclk_q;
    assign fall = tick && sclk_q;
    assign sclk = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half_q <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            half_q <= '0;
            sclk_q <= !sclk_q;
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    // R5: clock returns to its low idle level once a frame ends
    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !sclk_q);

endmodule

// File: rtl/adc_seq_dly.sv
module adc_seq_dly
    import adc_seq_pkg::*;
#(
    parameter int DT_W       = 8,
    parameter int SCALE_LOG2 = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [DT_W-1:0] dt,
    output logic            done
);
    localparam int CNT_W = DT_W + SCALE_LOG2 + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             busy_q;

    assign load_val = CNT_W'(post_cycles(32'(dt), DT_W, SCALE_LOG2)) - 1'b1;
    assign done     = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R6: a started quiet time is always counting on the next cycle
    p_dly_armed_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_q);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             capture,
    input  logic             din,
    output logic [RES_W-1:0] result,
    output logic             valid
);
    logic [RES_W-1:0] sh_q;
    logic [RES_W-1:0] res_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (sample) sh_q <= {sh_q[RES_W-2:0], din};
            if (capture) begin
                res_q <= {sh_q[RES_W-2:0], din};
                vld_q <= 1'b1;
            end
        end
    end

    assign result = res_q;
    assign valid  = vld_q;

    // R8: strobe never lasts two cycles
    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DT_W        = 8,
    parameter int SCALE_LOG2  = 5,
    parameter int NARROW_BITS = 8,
    parameter int WIDE_BITS   = 16,
    parameter int RES_W       = WIDE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [DT_W-1:0]  post_dt,
    input  logic             sdi,
    output logic             sclk,
    output logic             conv_n,
    output logic             cs_n,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);
    localparam int BIT_W = $clog2(WIDE_BITS);

    seq_state_e       state_q, state_d;
    logic             entry_q, entry_d;
    logic [BIT_W-1:0] bit_q, bit_d;

    logic             in_xfer, sck_rise, sck_fall;
    logic             wide_now, pdly_now, go;
    logic [BIT_W-1:0] last_idx;
    logic             at_last, frame_done, advance, stop_now;
    logic             dly_done, capture;

    assign go       = (baud_div != '0);
    assign in_xfer  = (state_q == ST_XFER);
    assign wide_now = entry_q ? CMD_READ.wide     : CMD_START.wide;
    assign pdly_now = entry_q ? CMD_READ.post_dly : CMD_START.post_dly;
    assign last_idx = wide_now ? BIT_W'(WIDE_BITS - 1) : BIT_W'(NARROW_BITS - 1);
    assign at_last  = (bit_q == last_idx);

    assign frame_done = in_xfer && sck_fall && at_last;
    assign advance    = (frame_done && !pdly_now) || (state_q == ST_WAIT && dly_done);
    assign stop_now   = entry_q && (!enable || !go);
    assign capture    = in_xfer && sck_rise && at_last && entry_q;

    always_comb begin
        state_d = state_q;
        entry_d = entry_q;
        bit_d   = bit_q;
        case (state_q)
            ST_IDLE: begin
                if (enable && go) begin
                    state_d = ST_XFER;
                    entry_d = 1'b0;
                    bit_d   = '0;
                end
            end
            ST_XFER: begin
                if (sck_fall) begin
                    if (at_last) begin
                        bit_d = '0;
                        if (pdly_now) state_d = ST_WAIT;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            default: ;
        endcase
        if (advance) begin
            if (stop_now) begin
                state_d = ST_IDLE;
                entry_d = 1'b0;
            end else begin
                state_d = ST_XFER;
                entry_d = !entry_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            entry_q <= 1'b0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            entry_q <= entry_d;
            bit_q   <= bit_d;
        end
    end

    assign conv_n = !in_xfer || (entry_q ? CMD_READ.sel_lvl[0] : CMD_START.sel_lvl[0]);
    assign cs_n   = !in_xfer || (entry_q ? CMD_READ.sel_lvl[1] : CMD_START.sel_lvl[1]);

    adc_seq_sclk #(.DIV_W(DIV_W)) sclk_i (
        .clk     (clk),
        .rst     (rst),
        .run     (in_xfer),
        .divisor (baud_div),
        .sclk    (sclk),
        .rise    (sck_rise),
        .fall    (sck_fall)
    );

    adc_seq_dly #(.DT_W(DT_W), .SCALE_LOG2(SCALE_LOG2)) dly_i (
        .clk   (clk),
        .rst   (rst),
        .start (frame_done && pdly_now),
        .dt    (post_dt),
        .done  (dly_done)
    );

    adc_seq_shift #(.RES_W(RES_W)) shift_i (
        .clk     (clk),
        .rst     (rst),
        .sample  (in_xfer && sck_rise),
        .capture (capture),
        .din     (sdi),
        .result  (result),
        .valid   (result_valid)
    );

    // R3: convert strobe only ever low inside a selected frame
    p_conv_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !conv_n |-> !cs_n);

    // R5: no clock activity outside a frame
    p_no_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R8: result strobe belongs to the read frame
    p_valid_in_read_r8: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (!cs_n && conv_n));

    // R9: the pass never ends to idle after the start frame
    p_stop_pass_end_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && dly_done && !entry_q) |=> (state_q == ST_XFER));

endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [7:0]  baud_div;
    logic [7:0]  post_dt;
    logic        sdi;
    logic        sclk, conv_n, cs_n, result_valid;
    logic [15:0] result;

    always #5 clk = !clk;

    adc_seq_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .baud_div     (baud_div),
        .post_dt      (post_dt),
        .sdi          (sdi),
        .sclk         (sclk),
        .conv_n       (conv_n),
        .cs_n         (cs_n),
        .result       (result),
        .result_valid (result_valid)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gap_cycles(int d);
        return 32 * ((d == 0) ? 256 : d);
    endfunction

    // ADC model: fresh word per pass, MSB first, updates on falling sclk
    logic [15:0] adc_word = 16'h0;
    int          bit_i = 15;

    always @(negedge conv_n) adc_word = 16'($urandom);
    always @(negedge cs_n) begin
        #1;
        bit_i = 15;
        sdi   = adc_word[15];
    end
    always @(negedge sclk) begin
        #1;
        if (bit_i > 0) bit_i--;
        sdi = adc_word[bit_i];
    end

    // Monitor
    int cfg_id = 0;
    int frame_cfg = -1;
    int lo_cnt = 0, hi_cnt = 0, rises = 0;
    int frames_done = 0, valid_cnt = 0;
    int conv_err = 0, sclk_err = 0;
    bit in_frame = 0, conv_seen = 0, have_gap = 0, prev_sclk = 0, prev_valid = 0;
    int exp_entry = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!conv_n && cs_n) conv_err++;
            if (!cs_n) begin
                if (!in_frame) begin
                    in_frame  = 1;
                    lo_cnt    = 0;
                    rises     = 0;
                    conv_seen = !conv_n;
                    if (frame_cfg != cfg_id) begin
                        exp_entry = 0;
                        have_gap  = 0;
                    end
                    check(conv_seen == (exp_entry == 0), "R4 entry order",
                          conv_seen, exp_entry == 0);
                    if (have_gap)
                        check(hi_cnt == gap_cycles(post_dt), "R6 quiet gap",
                              hi_cnt, gap_cycles(post_dt));
                    frame_cfg = cfg_id;
                end
                lo_cnt++;
                if (sclk && !prev_sclk) rises++;
                if ((!conv_n) != conv_seen) conv_err++;
            end else begin
                if (in_frame) begin
                    check(rises == (conv_seen ? 8 : 16), "R3 edges per frame",
                          rises, conv_seen ? 8 : 16);
                    check(lo_cnt == 2 * (conv_seen ? 8 : 16) * baud_div,
                          "R5 frame length", lo_cnt,
                          2 * (conv_seen ? 8 : 16) * baud_div);
                    exp_entry = 1 - exp_entry;
                    have_gap  = 1;
                    in_frame  = 0;
                    hi_cnt    = 1;
                    frames_done++;
                end else begin
                    hi_cnt++;
                end
                if (sclk) sclk_err++;
            end
            if (result_valid) begin
                check(result == adc_word, "R7 captured word", result, adc_word);
                check(!prev_valid, "R8 single pulse", prev_valid, 0);
                check(in_frame && !conv_seen, "R8 strobe in read frame",
                      conv_seen, 0);
                valid_cnt++;
            end
            prev_valid = result_valid;
            prev_sclk  = sclk;
        end
    end

    task automatic check_idle(string req);
        check(cs_n && conv_n, req, {cs_n, conv_n}, 3);
        check(!sclk && !result_valid, req, {sclk, result_valid}, 0);
    endtask

    task automatic run_cfg(int b, int d, int passes);
        int v0, v1, f1;
        @(negedge clk);
        cfg_id++;
        baud_div = 8'(b);
        post_dt  = 8'(d);
        v0 = valid_cnt;
        enable = 1'b1;
        wait (valid_cnt >= v0 + passes);
        check(valid_cnt - v0 == passes, "R8 one strobe per pass",
              valid_cnt - v0, passes);
        // drop enable right after a start frame begins
        @(negedge conv_n);
        @(negedge clk);
        enable = 1'b0;
        v1 = valid_cnt;
        f1 = frames_done;
        repeat (gap_cycles(d) * 2 + 100 * b + 200) @(negedge clk);
        check(frames_done == f1 + 2, "R9 pass completes then stops",
              frames_done - f1, 2);
        check(valid_cnt == v1 + 1, "R9 read frame still delivered",
              valid_cnt - v1, 1);
        check_idle("R1 idle after stop");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst      = 1'b1;
        enable   = 1'b0;
        baud_div = 8'd2;
        post_dt  = 8'd10;
        sdi      = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 reset state");
        check(result == 16'h0, "R1 reset result", result, 0);

        // R2: zero divider keeps it idle
        baud_div = 8'd0;
        enable   = 1'b1;
        repeat (300) @(negedge clk);
        check(frames_done == 0, "R2 no frame with zero divider", frames_done, 0);
        check_idle("R2 idle with zero divider");
        enable = 1'b0;
        repeat (5) @(negedge clk);

        // directed corners
        run_cfg(1, 1, 3);     // fastest clock, shortest gap
        run_cfg(2, 10, 2);    // nominal setting
        run_cfg(1, 0, 1);     // wrapped quiet time (8192 cycles)
        run_cfg(40, 1, 1);    // slow serial clock

        // seeded random settings
        for (int k = 0; k < 6; k++) begin
            run_cfg(1 + int'($urandom % 6), 1 + int'($urandom % 8), 2);
        end

        check(conv_err == 0, "R3 convert strobe only within read/start pattern",
              conv_err, 0);
        check(sclk_err == 0, "R5 sclk low outside frames", sclk_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule